// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Masks

This block is the arithmetic and logic stage of a small register-to-register core, together with the status register that it updates. Each cycle it takes two byte operands and a 4-bit operation code. It returns the byte result and the status byte that the operation would produce. When the operation is accepted, that status byte is written into the status register on the same clock edge. Each operation writes only its own fixed set of status bits and leaves every other bit as it was.

Two word operations add a 6-bit unsigned constant to a 16-bit register pair, or subtract it. They run through a small state machine in two steps, one for the low byte and one for the high byte. The state machine has two states. `WS_IDLE` accepts operations. `WS_HIGH` finishes the high byte of a word operation. The transition "start" (`WS_IDLE` to `WS_HIGH`) is taken when a word operation is accepted. The transition "finish" (`WS_HIGH` to `WS_IDLE`) is always taken on the following edge. `busy` is high in `WS_HIGH`, and any operation offered in that cycle is dropped.

Status byte layout, bit 7 to bit 0: I, T, H, S, V, N, Z, C. The I and T bits are never written by this block.

Operation codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement, 11 set-all, 12 word add, 13 word subtract. Codes 14 and 15 do nothing.

Top module: `flag_alu_unit`

## Requirements
- R1: After reset, `status_q`, `word_result` and `busy` are all zero, and status bits 7 (I) and 6 (T) keep their value through every operation.
- R2: Add (code 0) and add-with-carry (code 1) return a+b, or a+b+C for code 1. They write C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (bit 7 of the result), Z (result is zero) and S.
- R3: Subtract (code 2) returns a-b, and negate (code 8) returns 0x00-a. Both write C (borrow out of bit 7), H (borrow out of bit 3), V, N, Z and S.
- R4: Subtract-with-carry (code 3) returns a-b-C and writes C, H, V, N and S as subtract does. Z becomes 0 when the result is nonzero and keeps its old value when the result is zero.
- R5: AND, OR and XOR (codes 4, 5, 6) write N and Z from the result, clear V and update S. C and H keep their value.
- R6: One's complement (code 7) returns 0xFF-a. It sets C to 1, clears V, writes N, Z and S, and keeps H.
- R7: Increment (code 9) and decrement (code 10) return a+1 and a-1. V is set only for 0x7F+1 and for 0x80-1. They write N, Z and S, and C and H keep their value.
- R8: Set-all (code 11) returns 0xFF and leaves the whole status byte unchanged.
- R9: Every write of the arithmetic flags gives S = N XOR V.
- R10: Word add and word subtract (codes 12, 13) put the pair value plus or minus the zero-extended 6-bit constant on `word_result` two clock edges after acceptance, with `busy` high between those two edges. They write Z (16-bit result is zero), N (bit 15), V, C and S, and H keeps its value.
- R11: An operation offered while `busy` is high has no effect, and codes 14 and 15 leave the status byte unchanged and return a result of 0x00.
- R12: A byte operation that is accepted with `op_valid` loads the status register on that same clock edge. Before that edge, `status_nxt` already shows the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request to apply `op_code` on this edge |
| op_code | input | 4 | Operation selector |
| opnd_a | input | 8 | First byte operand |
| opnd_b | input | 8 | Second byte operand |
| word_in | input | 16 | Register-pair value for the word operations |
| imm_in | input | 6 | Unsigned constant for the word operations |
| result | output | 8 | Byte result, combinational from the operands |
| word_result | output | 16 | Registered result of the last word operation |
| busy | output | 1 | A word operation is in its second step |
| status_nxt | output | 8 | Status byte that the next edge will load |
| status_q | output | 8 | Registered status byte |

## Verification
A byte result depends only on the current inputs. It is sampled one time unit after the inputs change at the falling edge, and `status_nxt` is sampled at the same moment. At that point `status_q` must still hold the previous value. It must show the new value at the next falling edge, one register later. For a word operation, `busy` is checked at the falling edge after the accepting edge, and `word_result` and `status_q` are checked at the falling edge after the next rising edge. Because every check is made at a falling edge or just after one, no check samples a value on the same edge at which it changes.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int DATA_W = 8;
    localparam int WORD_W = 2 * DATA_W;
    localparam int IMM_W  = 6;
    localparam int OP_W   = 4;
    localparam int NIB_W  = 4;

    // status bit positions (bit order is visible to software)
    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_N = 2;
    localparam int FB_V = 3;
    localparam int FB_S = 4;
    localparam int FB_H = 5;
    localparam int FB_T = 6;
    localparam int FB_I = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_COM  = 4'd7,
        OP_NEG  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_SER  = 4'd11,
        OP_WADD = 4'd12,
        OP_WSUB = 4'd13
    } alu_op_e;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_HIGH = 1'b1
    } word_state_e;

    // which status bits each operation is allowed to write
    function automatic logic [7:0] flag_mask(input logic [OP_W-1:0] op);
        logic [7:0] m;
        m = 8'h00;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
                m = (8'd1 << FB_H) | (8'd1 << FB_S) | (8'd1 << FB_V) |
                    (8'd1 << FB_N) | (8'd1 << FB_Z) | (8'd1 << FB_C);
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:
                m = (8'd1 << FB_S) | (8'd1 << FB_V) | (8'd1 << FB_N) |
                    (8'd1 << FB_Z);
            OP_COM, OP_WADD, OP_WSUB:
                m = (8'd1 << FB_S) | (8'd1 << FB_V) | (8'd1 << FB_N) |
                    (8'd1 << FB_Z) | (8'd1 << FB_C);
            default: m = 8'h00;
        endcase
        return m;
    endfunction

    function automatic logic is_word_op(input logic [OP_W-1:0] op);
        return (op == OP_WADD) || (op == OP_WSUB);
    endfunction

endpackage

// File: rtl/byte_alu.sv
module byte_alu
    import alu_flag_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            cin,
    input  logic            zin,
    output logic [DW-1:0]   res,
    output logic [7:0]      cand
);

    localparam int MSB = DW - 1;

    logic [DW:0]      wide;
    logic [NIB_W:0]   nib;
    logic [DW-1:0]    x_op;
    logic [DW-1:0]    y_op;
    logic             cy;
    logic             f_c, f_h, f_v, f_z;

    always_comb begin
        wide = '0;
        nib  = '0;
        x_op = a;
        y_op = b;
        cy   = 1'b0;
        res  = '0;
        f_c  = 1'b0;
        f_h  = 1'b0;
        f_v  = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                cy   = (op == OP_ADC) ? cin : 1'b0;
                wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cy};
                nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cy};
                res  = wide[DW-1:0];
                f_c  = wide[DW];
                f_h  = nib[NIB_W];
                f_v  = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_SUB, OP_SBC, OP_NEG: begin
                x_op = (op == OP_NEG) ? '0 : a;
                y_op = (op == OP_NEG) ? a  : b;
                cy   = (op == OP_SBC) ? cin : 1'b0;
                wide = {1'b0, x_op} - {1'b0, y_op} - {{DW{1'b0}}, cy};
                nib  = {1'b0, x_op[NIB_W-1:0]} - {1'b0, y_op[NIB_W-1:0]} - {{NIB_W{1'b0}}, cy};
                res  = wide[DW-1:0];
                f_c  = wide[DW];
                f_h  = nib[NIB_W];
                f_v  = (x_op[MSB] != y_op[MSB]) && (res[MSB] != x_op[MSB]);
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_COM: begin
                res = ~a;
                f_c = 1'b1;
            end
            OP_INC: begin
                res = a + 1'b1;
                f_v = (a == {1'b0, {(DW-1){1'b1}}});
            end
            OP_DEC: begin
                res = a - 1'b1;
                f_v = (a == {1'b1, {(DW-1){1'b0}}});
            end
            OP_SER: res = '1;
            default: res = '0;
        endcase
        // chained compare: a zero byte cannot set Z, only keep it
        f_z = (op == OP_SBC) ? ((res == '0) && zin) : (res == '0);
        cand = '0;
        cand[FB_C] = f_c;
        cand[FB_Z] = f_z;
        cand[FB_N] = res[MSB];
        cand[FB_V] = f_v;
        cand[FB_S] = res[MSB] ^ f_v;
        cand[FB_H] = f_h;
    end

endmodule

// File: rtl/word_step.sv
module word_step
    import alu_flag_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            sub,
    input  logic [2*DW-1:0] word_in,
    input  logic [IW-1:0]   imm,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] word_q,
    output logic [7:0]      wflags
);

    localparam int MSB = DW - 1;

    word_state_e     state_q, state_d;
    logic [DW-1:0]   lo_q;
    logic [DW-1:0]   hi_op_q;
    logic            cy_q;
    logic            sub_q;
    logic [DW:0]     lo_sum;
    logic [DW-1:0]   hi_sum;
    logic [DW:0]     imm_ext;

    assign imm_ext = {{(DW+1-IW){1'b0}}, imm};
    assign lo_sum  = sub ? ({1'b0, word_in[DW-1:0]} - imm_ext)
                         : ({1'b0, word_in[DW-1:0]} + imm_ext);
    assign hi_sum  = sub_q ? (hi_op_q - {{(DW-1){1'b0}}, cy_q})
                           : (hi_op_q + {{(DW-1){1'b0}}, cy_q});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: if (start) state_d = WS_HIGH;
            WS_HIGH: state_d = WS_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_op_q <= '0;
            cy_q    <= 1'b0;
            sub_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            unique case (state_q)
                WS_IDLE: if (start) begin
                    lo_q    <= lo_sum[DW-1:0];
                    cy_q    <= lo_sum[DW];
                    hi_op_q <= word_in[2*DW-1:DW];
                    sub_q   <= sub;
                end
                WS_HIGH: word_q <= {hi_sum, lo_q};
            endcase
        end
    end

    assign busy = (state_q == WS_HIGH);
    assign done = busy;

    always_comb begin
        wflags = '0;
        wflags[FB_Z] = ({hi_sum, lo_q} == '0);
        wflags[FB_N] = hi_sum[MSB];
        wflags[FB_V] = sub_q ? (hi_op_q[MSB] & ~hi_sum[MSB]) : (~hi_op_q[MSB] & hi_sum[MSB]);
        wflags[FB_C] = sub_q ? (~hi_op_q[MSB] & hi_sum[MSB]) : (hi_op_q[MSB] & ~hi_sum[MSB]);
        wflags[FB_S] = wflags[FB_N] ^ wflags[FB_V];
    end

    // R10
    word_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R10
    word_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

endmodule

// File: rtl/flag_alu_unit.sv
module flag_alu_unit
    import alu_flag_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic [DW-1:0]   opnd_a,
    input  logic [DW-1:0]   opnd_b,
    input  logic [2*DW-1:0] word_in,
    input  logic [IW-1:0]   imm_in,
    output logic [DW-1:0]   result,
    output logic [2*DW-1:0] word_result,
    output logic            busy,
    output logic [7:0]      status_nxt,
    output logic [7:0]      status_q
);

    localparam logic [7:0] WORD_MASK = flag_mask(OP_WADD);

    logic       is_word;
    logic       byte_we;
    logic       word_go;
    logic       word_done;
    logic [7:0] byte_cand;
    logic [7:0] word_cand;
    logic [7:0] byte_mask;

    assign is_word   = is_word_op(op_code);
    assign byte_we   = op_valid && !busy && !is_word;
    assign word_go   = op_valid && !busy && is_word;
    assign byte_mask = flag_mask(op_code);

    byte_alu #(.DW(DW)) u_alu (
        .op   (op_code),
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (status_q[FB_C]),
        .zin  (status_q[FB_Z]),
        .res  (result),
        .cand (byte_cand)
    );

    word_step #(.DW(DW), .IW(IW)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (word_go),
        .sub     (op_code == OP_WSUB),
        .word_in (word_in),
        .imm     (imm_in),
        .busy    (busy),
        .done    (word_done),
        .word_q  (word_result),
        .wflags  (word_cand)
    );

    always_comb begin
        if (word_done)
            status_nxt = (word_cand & WORD_MASK) | (status_q & ~WORD_MASK);
        else if (byte_we)
            status_nxt = (byte_cand & byte_mask) | (status_q & ~byte_mask);
        else
            status_nxt = status_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nxt;
    end

    // R8
    ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && op_code == OP_SER) |=> $stable(status_q));
    // R7
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && (op_code == OP_INC || op_code == OP_DEC))
        |=> (status_q[FB_C] == $past(status_q[FB_C])) && (status_q[FB_H] == $past(status_q[FB_H])));
    // R6
    com_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && op_code == OP_COM) |=> status_q[FB_C]);
    // R9
    sign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[FB_S] == (status_q[FB_N] ^ status_q[FB_V]));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid && !is_word) |=> (status_q[FB_H] == $past(status_q[FB_H])));

endmodule

// File: tb/flag_alu_unit_tb_top.sv
module flag_alu_unit_tb_top;

    localparam int CLK_P = 10;
    localparam int NV    = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [7:0]  opnd_a = 8'h00;
    logic [7:0]  opnd_b = 8'h00;
    logic [15:0] word_in = 16'h0000;
    logic [5:0]  imm_in = 6'd0;
    logic [7:0]  result;
    logic [15:0] word_result;
    logic        busy;
    logic [7:0]  status_nxt;
    logic [7:0]  status_q;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    flag_alu_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .word_in(word_in), .imm_in(imm_in),
        .result(result), .word_result(word_result), .busy(busy),
        .status_nxt(status_nxt), .status_q(status_q)
    );

    // {op, a, b, expected result, expected status, requirement number}
    localparam logic [39:0] VEC [NV] = '{
        {4'd0,  8'h3A, 8'h0C, 8'h46, 8'h20, 4'd2},  // R2 half carry
        {4'd0,  8'h80, 8'h80, 8'h00, 8'h1B, 4'd2},  // R2 carry+overflow+zero
        {4'd1,  8'h10, 8'h20, 8'h31, 8'h00, 4'd2},  // R2 carry in
        {4'd2,  8'h10, 8'h01, 8'h0F, 8'h20, 4'd3},  // R3 half borrow
        {4'd2,  8'h05, 8'h06, 8'hFF, 8'h35, 4'd3},  // R3 borrow
        {4'd3,  8'h00, 8'h00, 8'hFF, 8'h35, 4'd4},  // R4 borrow in, nonzero
        {4'd2,  8'h42, 8'h42, 8'h00, 8'h02, 4'd3},  // R3 zero
        {4'd3,  8'h33, 8'h33, 8'h00, 8'h02, 4'd4},  // R4 Z kept at 1
        {4'd2,  8'h00, 8'h01, 8'hFF, 8'h35, 4'd3},  // R3
        {4'd4,  8'hF0, 8'h3C, 8'h30, 8'h21, 4'd5},  // R5 C,H kept
        {4'd3,  8'h07, 8'h06, 8'h00, 8'h00, 4'd4},  // R4 Z kept at 0
        {4'd5,  8'h80, 8'h01, 8'h81, 8'h14, 4'd5},  // R5
        {4'd6,  8'h5A, 8'h5A, 8'h00, 8'h02, 4'd5},  // R5
        {4'd7,  8'h00, 8'h00, 8'hFF, 8'h15, 4'd6},  // R6
        {4'd9,  8'h7F, 8'h00, 8'h80, 8'h0D, 4'd7},  // R7 overflow
        {4'd10, 8'h80, 8'h00, 8'h7F, 8'h19, 4'd7},  // R7 overflow
        {4'd9,  8'hFF, 8'h00, 8'h00, 8'h03, 4'd7},  // R7 wrap, C kept
        {4'd8,  8'h01, 8'h00, 8'hFF, 8'h35, 4'd3},  // R3 negate
        {4'd8,  8'h80, 8'h00, 8'h80, 8'h0D, 4'd3},  // R3 negate overflow
        {4'd11, 8'h12, 8'h34, 8'hFF, 8'h0D, 4'd8},  // R8
        {4'd8,  8'h00, 8'h00, 8'h00, 8'h02, 4'd3},  // R3 negate zero
        {4'd10, 8'h01, 8'h00, 8'h00, 8'h02, 4'd7}   // R7
    };

    task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // byte operation: drive at falling edge, check comb outputs, then registered status
    task automatic do_byte(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] er, input logic [7:0] ef, input int req);
        logic [7:0] prev;
        prev = status_q;
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
        #1;
        check($sformatf("R%0d result op%0d", req, op), {8'h00, result}, {8'h00, er});
        check($sformatf("R12 status_nxt op%0d", op), {8'h00, status_nxt}, {8'h00, ef});
        check("R12 status held before edge", {8'h00, status_q}, {8'h00, prev});
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        check($sformatf("R%0d status op%0d", req, op), {8'h00, status_q}, {8'h00, ef});
    endtask

    task automatic do_word(input logic sub, input logic [15:0] w, input logic [5:0] k,
                           input logic [15:0] ew, input logic [7:0] ef, input logic poke);
        op_valid = 1'b1; op_code = sub ? 4'd13 : 4'd12; word_in = w; imm_in = k;
        @(posedge clk);
        @(negedge clk);
        check("R10 busy after start", {15'd0, busy}, 16'd1);
        if (poke) begin
            // R11 offered during busy: must be dropped
            op_code = 4'd0; opnd_a = 8'h80; opnd_b = 8'h80;
        end else begin
            op_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        check("R10 word result", word_result, ew);
        check("R10 word status", {8'h00, status_q}, {8'h00, ef});
        check("R10 busy cleared", {15'd0, busy}, 16'd0);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status after reset", {8'h00, status_q}, 16'h0000);
        check("R1 word result after reset", word_result, 16'h0000);
        check("R1 busy after reset", {15'd0, busy}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            do_byte(VEC[i][39:36], VEC[i][35:28], VEC[i][27:20],
                    VEC[i][19:12], VEC[i][11:4], int'(VEC[i][3:0]));
        end

        // R10 word operations
        do_word(1'b0, 16'h00FF, 6'd1,  16'h0100, 8'h00, 1'b0);
        do_word(1'b0, 16'hFFFF, 6'd1,  16'h0000, 8'h03, 1'b0);
        do_word(1'b0, 16'h7FFF, 6'h3F, 16'h803E, 8'h0C, 1'b0);
        do_word(1'b1, 16'h0000, 6'd1,  16'hFFFF, 8'h15, 1'b0);
        do_byte(4'd2, 8'h10, 8'h01, 8'h0F, 8'h20, 3);
        // H kept through a word op; byte add offered while busy is dropped (R11)
        do_word(1'b1, 16'h8000, 6'd1,  16'h7FFF, 8'h38, 1'b1);

        // R11 unused codes
        do_byte(4'd14, 8'hAA, 8'h55, 8'h00, 8'h38, 11);
        do_byte(4'd15, 8'h00, 8'h00, 8'h00, 8'h38, 11);

        // R1 I and T never written
        check("R1 I/T bits", {14'd0, status_q[7:6]}, 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule